// File: doc/BRIEF.md
# Latched-Address Static RAM Core

This block is a 256-word by 4-bit static memory that runs under a free-running system clock. It has separate 4-bit write and read data paths. An active-low enable strobe frames each access. The clock samples every pin, and the block detects the strobe's edges by comparing successive samples. When the block sees the strobe fall, it captures the address and both active-low chip selects. These captured values stay in force until the strobe returns high, whatever the pins do in the meantime.

Inside, the storage is a matrix of 32 rows by 32 bits. Five address bits choose the row and three choose a 4-bit group within it. In a selected cycle with the write strobe low, the input nibble is stored at the captured word and the output stays off. In a selected cycle with the write strobe high, the stored nibble is loaded into an output holding register and its three-state enable is raised. When the cycle ends, the enable drops, but the holding register keeps the last value read. Several instances can therefore share one read bus.

Top module: `latched_sram_core`

## Requirements
- R1: While the synchronous active-low reset is held, and after it is released, `dout_oe_o` is 0 and `dout_o` is 0 until the first read.
- R2: A cycle is selected when `cs1_n_i` and `cs2_n_i` are both 0 at the moment the enable fall is seen. In a selected cycle with `we_n_i` = 0, `din_i` is stored at the captured word, and `dout_oe_o` stays 0 for the whole cycle.
- R3: In a selected cycle with `we_n_i` = 1, `dout_oe_o` rises and `dout_o` shows the stored nibble no later than 4 clocks after `stb_n_i` falls.
- R4: The address sampled on the clock where the fall of `stb_n_i` is first seen is held for the cycle. Changing `addr_i` from the following clock onward affects neither the word read nor the word written.
- R5: A cycle that is not selected writes nothing and leaves `dout_oe_o` at 0 and `dout_o` unchanged.
- R6: The selects are captured with the address. Toggling `cs1_n_i` or `cs2_n_i` later in the cycle neither enables a deselected cycle nor disables a selected one.
- R7: Within 3 clocks of `stb_n_i` rising, `dout_oe_o` returns to 0, and `dout_o` keeps the last value read until the next read.
- R8: All 256 addresses are distinct words. The row is {a7,a6,a5,a1,a0} and the 4-bit group within the row is {a4,a3,a2}. Words that differ only in the group bits share a row but never alias.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all pins |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_i | input | 8 | Word address |
| din_i | input | 4 | Write data nibble |
| stb_n_i | input | 1 | Active-low cycle enable strobe |
| we_n_i | input | 1 | Active-low write enable |
| cs1_n_i | input | 1 | Active-low chip select, first |
| cs2_n_i | input | 1 | Active-low chip select, second |
| dout_o | output | 4 | Read data from the output holding register |
| dout_oe_o | output | 1 | Three-state enable for `dout_o`, high drives the bus |

## Verification
Two events can land in the same cycle: the capture of the address and selects, and a change on those same pins. The bench provokes this by scrambling the address on the clock right after the fall is seen, and in many cycles by also inverting both selects. It then judges every read against a reference array and every write by a later readback. The end of a cycle and the release of the write strobe can also coincide. The bench raises both on the same clock and then checks that the enable has dropped, that the held read data is unchanged, and that the stored word still matches the reference.

// File: rtl/lsram_pkg.sv
package lsram_pkg;
   localparam int ADDR_W = 8;
   localparam int DATA_W = 4;
   localparam int ROW_W  = 5;
   localparam int COL_W  = 3;

   typedef struct packed {
      logic [ADDR_W-1:0] addr;
      logic              sel_ok;
   } cyc_capture_t;

   function automatic logic [ROW_W-1:0] row_field(input logic [ADDR_W-1:0] a);
      return {a[7], a[6], a[5], a[1], a[0]};
   endfunction

   function automatic logic [COL_W-1:0] col_field(input logic [ADDR_W-1:0] a);
      return {a[4], a[3], a[2]};
   endfunction
endpackage

// File: rtl/lsram_pin_sampler.sv
module lsram_pin_sampler #(
   parameter int N_STAGES = 1,
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] din_i,
   input  logic              stb_n_i,
   input  logic              we_n_i,
   input  logic              cs1_n_i,
   input  logic              cs2_n_i,
   output logic [ADDR_W-1:0] s_addr,
   output logic [DATA_W-1:0] s_din,
   output logic              s_we_n,
   output logic [1:0]        s_cs_n,
   output logic              stb_fall,
   output logic              stb_rise
);
   localparam int VEC_W = ADDR_W + DATA_W + 4;
   localparam logic [VEC_W-1:0] IDLE_VEC = {{(ADDR_W + DATA_W){1'b0}}, 4'b1111};

   logic [VEC_W-1:0] raw_vec;
   logic [VEC_W-1:0] last_vec;
   logic             s_stb_n;
   logic             stb_prev;

   assign raw_vec = {addr_i, din_i, stb_n_i, we_n_i, cs2_n_i, cs1_n_i};

   generate
      if (N_STAGES <= 1) begin : g_single
         always_ff @(posedge clk) begin
            if (!rst_n) last_vec <= IDLE_VEC;
            else        last_vec <= raw_vec;
         end
      end else begin : g_chain
         logic [VEC_W-1:0] stg [N_STAGES];
         for (genvar i = 0; i < N_STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
               if (!rst_n)      stg[i] <= IDLE_VEC;
               else if (i == 0) stg[i] <= raw_vec;
               else             stg[i] <= stg[i-1];
            end
         end
         assign last_vec = stg[N_STAGES-1];
      end
   endgenerate

   assign s_addr  = last_vec[VEC_W-1 -: ADDR_W];
   assign s_din   = last_vec[DATA_W+3 -: DATA_W];
   assign s_stb_n = last_vec[3];
   assign s_we_n  = last_vec[2];
   assign s_cs_n  = last_vec[1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) stb_prev <= 1'b1;
      else        stb_prev <= s_stb_n;
   end

   assign stb_fall = stb_prev & ~s_stb_n;
   assign stb_rise = ~stb_prev & s_stb_n;
endmodule

// File: rtl/lsram_cycle_ctl.sv
module lsram_cycle_ctl
   import lsram_pkg::*;
#(
   parameter int AW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          stb_fall,
   input  logic          stb_rise,
   input  logic [AW-1:0] s_addr,
   input  logic [1:0]    s_cs_n,
   input  logic          s_we_n,
   output logic          cyc_act,
   output logic [AW-1:0] lat_addr,
   output logic          lat_sel_ok,
   output logic          wr_stb,
   output logic          rd_open
);
   logic live;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cyc_act    <= 1'b0;
         lat_addr   <= '0;
         lat_sel_ok <= 1'b0;
      end else if (stb_fall) begin
         cyc_act    <= 1'b1;
         lat_addr   <= s_addr;
         lat_sel_ok <= ~|s_cs_n;
      end else if (stb_rise) begin
         cyc_act    <= 1'b0;
      end
   end

   assign live    = cyc_act & lat_sel_ok & ~stb_rise;
   assign wr_stb  = live & ~s_we_n;
   assign rd_open = live & s_we_n;
endmodule

// File: rtl/lsram_matrix.sv
module lsram_matrix #(
   parameter int ROWS   = 32,
   parameter int ROW_W  = 5,
   parameter int COL_W  = 3,
   parameter int DATA_W = 4
) (
   input  logic              clk,
   input  logic              wr_stb,
   input  logic [ROW_W-1:0]  row,
   input  logic [COL_W-1:0]  col,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   localparam int ROW_BITS = DATA_W * (1 << COL_W);

   logic [ROW_BITS-1:0] rows_q [ROWS];

   generate
      for (genvar r = 0; r < ROWS; r++) begin : g_row
         logic row_hit;
         assign row_hit = (row == ROW_W'(r));
         always_ff @(posedge clk) begin
            if (wr_stb && row_hit)
               rows_q[r][col*DATA_W +: DATA_W] <= wdata;
         end
      end
   endgenerate

   logic [ROW_BITS-1:0] row_sel;
   always_comb begin
      row_sel = rows_q[row];
      rdata   = row_sel[col*DATA_W +: DATA_W];
   end
endmodule

// File: rtl/lsram_out_stage.sv
module lsram_out_stage #(
   parameter int DATA_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_open,
   input  logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] dout_q,
   output logic              oe_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dout_q <= '0;
         oe_q   <= 1'b0;
      end else begin
         oe_q <= rd_open;
         if (rd_open) dout_q <= rdata;
      end
   end
endmodule

// File: rtl/latched_sram_core.sv
module latched_sram_core
   import lsram_pkg::*;
#(
   parameter int AW       = ADDR_W,
   parameter int DW       = DATA_W,
   parameter int RW       = ROW_W,
   parameter int CW       = COL_W,
   parameter int N_STAGES = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] addr_i,
   input  logic [DW-1:0] din_i,
   input  logic          stb_n_i,
   input  logic          we_n_i,
   input  logic          cs1_n_i,
   input  logic          cs2_n_i,
   output logic [DW-1:0] dout_o,
   output logic          dout_oe_o
);
   localparam int ROWS = 1 << RW;

   initial begin
      if (AW != RW + CW) $error("address width must equal row plus column widths");
      if (AW != ADDR_W || RW != ROW_W || CW != COL_W)
         $error("field split is fixed by the package");
      if (N_STAGES < 1 || N_STAGES > 3) $error("N_STAGES must be 1 to 3");
   end

   logic [AW-1:0] s_addr;
   logic [DW-1:0] s_din;
   logic          s_we_n;
   logic [1:0]    s_cs_n;
   logic          stb_fall, stb_rise;
   logic          cyc_act, lat_sel_ok, wr_stb, rd_open;
   logic [AW-1:0] lat_addr;
   logic [DW-1:0] rdata;

   lsram_pin_sampler #(.N_STAGES(N_STAGES), .ADDR_W(AW), .DATA_W(DW)) u_smp (
      .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .din_i(din_i),
      .stb_n_i(stb_n_i), .we_n_i(we_n_i), .cs1_n_i(cs1_n_i), .cs2_n_i(cs2_n_i),
      .s_addr(s_addr), .s_din(s_din), .s_we_n(s_we_n), .s_cs_n(s_cs_n),
      .stb_fall(stb_fall), .stb_rise(stb_rise)
   );

   lsram_cycle_ctl #(.AW(AW)) u_ctl (
      .clk(clk), .rst_n(rst_n), .stb_fall(stb_fall), .stb_rise(stb_rise),
      .s_addr(s_addr), .s_cs_n(s_cs_n), .s_we_n(s_we_n),
      .cyc_act(cyc_act), .lat_addr(lat_addr), .lat_sel_ok(lat_sel_ok),
      .wr_stb(wr_stb), .rd_open(rd_open)
   );

   lsram_matrix #(.ROWS(ROWS), .ROW_W(RW), .COL_W(CW), .DATA_W(DW)) u_mat (
      .clk(clk), .wr_stb(wr_stb),
      .row(row_field(lat_addr)), .col(col_field(lat_addr)),
      .wdata(s_din), .rdata(rdata)
   );

   lsram_out_stage #(.DATA_W(DW)) u_out (
      .clk(clk), .rst_n(rst_n), .rd_open(rd_open), .rdata(rdata),
      .dout_q(dout_o), .oe_q(dout_oe_o)
   );
endmodule

// File: rtl/lsram_core_checks.sv
module lsram_core_checks #(
   parameter int AW = 8,
   parameter int DW = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cyc_act,
   input logic [AW-1:0] lat_addr,
   input logic          lat_sel_ok,
   input logic          wr_stb,
   input logic          rd_open,
   input logic          stb_rise,
   input logic [DW-1:0] dout_o,
   input logic          dout_oe_o
);
   p_oe_needs_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      dout_oe_o |-> $past(cyc_act));

   p_no_oe_on_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> !dout_oe_o);

   p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_act && $past(cyc_act)) |-> $stable(lat_addr));

   p_sel_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_act && $past(cyc_act)) |-> $stable(lat_sel_ok));

   p_dout_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_open |=> $stable(dout_o));

   p_end_closes_r7: assert property (@(posedge clk) disable iff (!rst_n)
      stb_rise |=> ##1 !dout_oe_o);

   p_deselect_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_act && !lat_sel_ok) |=> !dout_oe_o);
endmodule

bind latched_sram_core lsram_core_checks #(.AW(AW), .DW(DW)) u_chk (
   .clk(clk), .rst_n(rst_n), .cyc_act(cyc_act), .lat_addr(lat_addr),
   .lat_sel_ok(lat_sel_ok), .wr_stb(wr_stb), .rd_open(rd_open),
   .stb_rise(stb_rise), .dout_o(dout_o), .dout_oe_o(dout_oe_o)
);

// File: tb/latched_sram_core_test.sv
`timescale 1ns/1ps
module latched_sram_core_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] addr_i = '0;
   logic [3:0] din_i = '0;
   logic       stb_n_i = 1'b1, we_n_i = 1'b1, cs1_n_i = 1'b1, cs2_n_i = 1'b1;
   logic [3:0] dout_o;
   logic       dout_oe_o;

   int   n_checks = 0;
   int   n_fail = 0;
   bit   done = 0;
   logic [3:0] refm [256];
   logic [3:0] last_q = 4'h0;

   always #2.5 clk = ~clk;

   latched_sram_core uut (
      .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .din_i(din_i),
      .stb_n_i(stb_n_i), .we_n_i(we_n_i), .cs1_n_i(cs1_n_i), .cs2_n_i(cs2_n_i),
      .dout_o(dout_o), .dout_oe_o(dout_oe_o)
   );

   function automatic logic is_selected(input logic c1_n, input logic c2_n);
      return !c1_n && !c2_n;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
      end
   endtask

   task automatic run_cycle(input logic [7:0] a, input logic wr, input logic [3:0] d,
                            input logic c1_n, input logic c2_n, input logic flip_sel,
                            input logic flip_addr);
      logic sel;
      sel = is_selected(c1_n, c2_n);
      addr_i = a; din_i = d; we_n_i = ~wr; cs1_n_i = c1_n; cs2_n_i = c2_n;
      stb_n_i = 1'b0;
      repeat (2) @(negedge clk);
      if (flip_addr) addr_i = ~a ^ 8'h15;           // R4 pins move after capture
      if (flip_sel) begin cs1_n_i = ~c1_n; cs2_n_i = ~c2_n; end  // R6
      repeat (3) @(negedge clk);
      if (sel && !wr) begin
         chk(dout_oe_o === 1'b1, "R3 oe", dout_oe_o, 1);
         chk(dout_o === refm[a], "R3/R4/R8 data", dout_o, refm[a]);
         last_q = refm[a];
      end else if (sel) begin
         chk(dout_oe_o === 1'b0, "R2 oe during write", dout_oe_o, 0);
      end else begin
         chk(dout_oe_o === 1'b0, "R5/R6 deselected oe", dout_oe_o, 0);
         chk(dout_o === last_q, "R5 dout unchanged", dout_o, last_q);
      end
      if (sel && wr) refm[a] = d;
      stb_n_i = 1'b1; we_n_i = 1'b1;                // end and write release together
      repeat (4) @(negedge clk);
      chk(dout_oe_o === 1'b0, "R7 oe after end", dout_oe_o, 0);
      chk(dout_o === last_q, "R7 dout held", dout_o, last_q);
   endtask

   initial begin
      void'($urandom(32'h5A17));
      repeat (3) @(negedge clk);
      chk(dout_oe_o === 1'b0, "R1 oe in reset", dout_oe_o, 0);
      chk(dout_o === 4'h0, "R1 dout in reset", dout_o, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(dout_oe_o === 1'b0, "R1 oe after reset", dout_oe_o, 0);

      // R2, R8: fill every word, then read all back
      for (int i = 0; i < 256; i++)
         run_cycle(8'(i), 1'b1, 4'($urandom), 1'b0, 1'b0, 1'b0, i[0]);
      for (int i = 0; i < 256; i++)
         run_cycle(8'(i), 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, i[1]);

      // R8 directed: group bits only differ, same row
      run_cycle(8'h00, 1'b1, 4'hA, 1'b0, 1'b0, 1'b0, 1'b0);
      run_cycle(8'h1C, 1'b1, 4'h5, 1'b0, 1'b0, 1'b0, 1'b0);
      run_cycle(8'h00, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b1);
      run_cycle(8'h1C, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b1);

      // R5: deselected write must not store, each select alone
      run_cycle(8'h42, 1'b1, ~refm[8'h42], 1'b1, 1'b0, 1'b0, 1'b0);
      run_cycle(8'h42, 1'b1, ~refm[8'h42], 1'b0, 1'b1, 1'b0, 1'b0);
      run_cycle(8'h42, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0);
      // R6: select appears late, and disappears late
      run_cycle(8'h42, 1'b1, ~refm[8'h42], 1'b1, 1'b1, 1'b1, 1'b1);
      run_cycle(8'h42, 1'b0, 4'h0, 1'b0, 1'b0, 1'b1, 1'b1);
      run_cycle(8'h99, 1'b1, 4'h3, 1'b0, 1'b0, 1'b1, 1'b1);
      run_cycle(8'h99, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0);

      // random mix
      for (int k = 0; k < 600; k++) begin
         logic [2:0] op;
         op = 3'($urandom);
         run_cycle(8'($urandom), op[0], 4'($urandom),
                   op[1] & op[2], op[1] & ~op[2], 1'($urandom), 1'($urandom));
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end
endmodule